// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the single 32-bit control and status word of a floating-point unit and serves it to software through several narrower windows that alias parts of the same storage. Each window is chosen by a 5-bit control-register index on a shared read/write port. The condition-code view closes the one-bit hole that the flush-to-zero bit leaves between condition code 0 and codes 1 to 7. The exception view covers only the cause and sticky-flag fields. The enables view covers rounding mode, enables and flush-to-zero. The full view shows the whole word. A fixed identification constant sits at index 0.

The arithmetic datapath reports each completed operation on a status-update port as six flags. The unit replaces the cause field with them, raises a one-cycle trap pulse when an enabled cause or the unimplemented cause is present, and then ORs all causes except unimplemented into the sticky flags. The rounding mode, the flush-to-zero bit and the gap-closed condition codes are driven out continuously for the datapath.

Top module: `fpcsr_unit`

## Requirements
- R1: After a synchronous active-low reset the whole word is zero. `rm_o`, `fs_o`, `fcc_o` and `trap_o` are low, and the full view reads 0.
- R2: Index 0 reads the parameter `IMPL_REV` (default 32'h0000_0A31). Writes to index 0 or to any index other than 25, 26, 28 and 31 change nothing. Reads of those other indices return 0, and `rdata_o` is 0 whenever `rd_en_i` is low.
- R3: Word layout for the condition codes: code 0 is bit 23 and codes 1 to 7 are bits 25 to 31. Index 25 reads {code7..code1, code0} in bits 7:0 and zero above. A write there stores `wdata_i[0]` as code 0 and `wdata_i[7:1]` as codes 1 to 7, and leaves every other field as it was.
- R4: Index 26 reads the cause field (bits 17:12) and the sticky flags (bits 6:2) in place, with zero elsewhere. A write there replaces only those two fields.
- R5: Index 28 reads the rounding mode in bits 1:0, flush-to-zero in bit 2 and the enables in bits 11:7. A write there takes all three from those same bits and keeps the condition codes, cause and flags.
- R6: Index 31 reads and writes the whole word. Bits 22:18 are reserved and always read as zero.
- R7: A status update replaces the cause field with `status_i`. The bit order is 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid and 5 unimplemented, mapped to word bits 12 to 17 in that order.
- R8: `trap_o` is high for exactly the cycle after an update in which `status_i[4:0]` meets a set enable (the enables use the same order in bits 7 to 11) or `status_i[5]` is set. It is low in every other cycle.
- R9: An update ORs `status_i[4:0]` into the sticky flags (same order, bits 2 to 6). The unimplemented cause is never made sticky. Flags are cleared only by writes to index 26 or 31.
- R10: `rm_o` mirrors bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), `fs_o` mirrors bit 24 and `fcc_o` mirrors the gap-closed codes.
- R11: When a write and an update arrive in the same cycle, the write is applied first and the update is merged on top of it. The trap test uses the enables just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en_i | input | 1 | Read strobe, combinational read data |
| wr_en_i | input | 1 | Write strobe, takes effect at the clock edge |
| idx_i | input | 5 | Control-register index for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected view |
| upd_valid_i | input | 1 | Status update from the datapath |
| status_i | input | 6 | Operation flags, order as in R7 |
| rm_o | output | 2 | Rounding mode |
| fs_o | output | 1 | Flush-to-zero |
| fcc_o | output | 8 | Condition codes, gap closed |
| trap_o | output | 1 | Floating-point exception trap pulse |

## Verification
The condition codes are stored with a gap in the word. A shifted or overlapping placement shows at once on the next read of index 25 or 31, and on `fcc_o` in the cycle after the write. A fault in the sticky-versus-cause handling shows only when a second update follows the first without a clear, so the sweeps chain two updates and read index 26 after each. A trap computed from stale enables or with a missing unimplemented override shows as a wrong `trap_o` level one cycle after the update.

// File: rtl/fpcsr_pkg.sv
// Package: field layout, view indices and gap helpers for the FP control word.
// Assumes a 32-bit word with the condition codes split around flush-to-zero.
package fpcsr_pkg;

    localparam int CSR_W   = 32;
    localparam int IDX_W   = 5;
    localparam int FCC_N   = 8;
    localparam int EXC_N   = 6;
    localparam int FLG_N   = EXC_N - 1;
    localparam int UNIMP_B = EXC_N - 1;

    localparam int RM_LSB   = 0;
    localparam int FLG_LSB  = 2;
    localparam int ENA_LSB  = 7;
    localparam int CAU_LSB  = 12;
    localparam int FCC0_POS = 23;
    localparam int FS_POS   = 24;
    localparam int FCCH_LSB = 25;
    localparam int FS_VIEW_POS = 2;

    localparam logic [CSR_W-1:0] RM_MASK  = 32'h0000_0003;
    localparam logic [CSR_W-1:0] FLG_MASK = 32'h0000_007C;
    localparam logic [CSR_W-1:0] ENA_MASK = 32'h0000_0F80;
    localparam logic [CSR_W-1:0] CAU_MASK = 32'h0003_F000;
    localparam logic [CSR_W-1:0] RSV_MASK = 32'h007C_0000;
    localparam logic [CSR_W-1:0] FCC_MASK = 32'hFE80_0000;
    localparam logic [CSR_W-1:0] FS_MASK  = 32'h0100_0000;

    typedef enum logic [IDX_W-1:0] {
        VIEW_ID  = 5'd0,
        VIEW_CC  = 5'd25,
        VIEW_EXC = 5'd26,
        VIEW_ENA = 5'd28,
        VIEW_ALL = 5'd31
    } view_e;

    // Collect the eight condition codes with the flush-to-zero hole removed.
    function automatic logic [FCC_N-1:0] fcc_gather(input logic [CSR_W-1:0] w);
        return {w[CSR_W-1:FCCH_LSB], w[FCC0_POS]};
    endfunction

    // Spread eight condition codes back into their word positions.
    function automatic logic [CSR_W-1:0] fcc_scatter(input logic [FCC_N-1:0] c);
        logic [CSR_W-1:0] w;
        w = '0;
        w[FCC0_POS] = c[0];
        w[CSR_W-1:FCCH_LSB] = c[FCC_N-1:1];
        return w;
    endfunction

endpackage

// File: rtl/fpcsr_wr_merge.sv
// Module: fpcsr_wr_merge
// Applies a software write through one of the aliased views to the current
// word. Purely combinational; assumes the caller registers the result.
module fpcsr_wr_merge
    import fpcsr_pkg::*;
(
    input  logic [CSR_W-1:0] cur_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CSR_W-1:0] wdata_i,
    output logic [CSR_W-1:0] nxt_o
);

    localparam logic [CSR_W-1:0] EXC_MASK  = CAU_MASK | FLG_MASK;
    localparam logic [CSR_W-1:0] KEEP_ENA  = FCC_MASK | CAU_MASK | FLG_MASK;
    localparam logic [CSR_W-1:0] TAKE_ENA  = ENA_MASK | RM_MASK;

    logic [CSR_W-1:0] cc_spread;
    logic [CSR_W-1:0] fs_from_view;

    // Expand the write data for the condition-code and enables views.
    always_comb begin
        cc_spread    = fcc_scatter(wdata_i[FCC_N-1:0]);
        fs_from_view = wdata_i[FS_VIEW_POS] ? FS_MASK : '0;
    end

    // Select which fields the addressed view replaces.
    always_comb begin
        nxt_o = cur_i;
        if (wr_en_i) begin
            case (idx_i)
                VIEW_CC:  nxt_o = (cur_i & ~FCC_MASK) | cc_spread;
                VIEW_EXC: nxt_o = (cur_i & ~EXC_MASK) | (wdata_i & EXC_MASK);
                VIEW_ENA: nxt_o = (cur_i & KEEP_ENA) | (wdata_i & TAKE_ENA) | fs_from_view;
                VIEW_ALL: nxt_o = wdata_i & ~RSV_MASK;
                default:  nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/fpcsr_exc_merge.sv
// Module: fpcsr_exc_merge
// Merges one operation's status flags into the word: the cause is replaced,
// the trap is tested, then causes other than unimplemented become sticky.
// Assumes base_i already holds any same-cycle software write.
module fpcsr_exc_merge
    import fpcsr_pkg::*;
(
    input  logic [CSR_W-1:0] base_i,
    input  logic             upd_valid_i,
    input  logic [EXC_N-1:0] status_i,
    output logic [CSR_W-1:0] nxt_o,
    output logic             trap_req_o
);

    logic [FLG_N-1:0] enables;
    logic [FLG_N-1:0] hit;

    // Compare the new causes against the enables in force.
    always_comb begin
        enables = base_i[ENA_LSB +: FLG_N];
        hit     = status_i[FLG_N-1:0] & enables;
        trap_req_o = upd_valid_i && ((|hit) || status_i[UNIMP_B]);
    end

    // Replace cause, then accumulate the sticky flags.
    always_comb begin
        nxt_o = base_i;
        if (upd_valid_i) begin
            nxt_o = base_i & ~CAU_MASK;
            nxt_o[CAU_LSB +: EXC_N] = status_i;
            nxt_o[FLG_LSB +: FLG_N] = base_i[FLG_LSB +: FLG_N] | status_i[FLG_N-1:0];
        end
    end

endmodule

// File: rtl/fpcsr_rd_view.sv
// Module: fpcsr_rd_view
// Forms the read data for the addressed view of the word; unused view bits
// read as zero. Combinational; assumes the read strobe qualifies the output.
module fpcsr_rd_view
    import fpcsr_pkg::*;
#(
    parameter logic [CSR_W-1:0] IMPL_REV = 32'h0000_0A31
) (
    input  logic [CSR_W-1:0] csr_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [CSR_W-1:0] rdata_o
);

    localparam logic [CSR_W-1:0] EXC_MASK = CAU_MASK | FLG_MASK;
    localparam logic [CSR_W-1:0] ENA_VIEW = ENA_MASK | RM_MASK;

    logic [CSR_W-1:0] cc_view;
    logic [CSR_W-1:0] ena_view;

    // Build the two views that move bits away from their word positions.
    always_comb begin
        cc_view  = '0;
        cc_view[FCC_N-1:0] = fcc_gather(csr_i);
        ena_view = csr_i & ENA_VIEW;
        ena_view[FS_VIEW_POS] = csr_i[FS_POS];
    end

    // Multiplex the addressed view onto the read bus.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (idx_i)
                VIEW_ID:  rdata_o = IMPL_REV;
                VIEW_CC:  rdata_o = cc_view;
                VIEW_EXC: rdata_o = csr_i & EXC_MASK;
                VIEW_ENA: rdata_o = ena_view;
                VIEW_ALL: rdata_o = csr_i & ~RSV_MASK;
                default:  rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/fpcsr_unit.sv
// Module: fpcsr_unit (top)
// Holds the FP control/status word and its trap pulse. A software write is
// applied first, a datapath status update is merged on top, and the result
// is registered. Synchronous active-low reset clears everything.
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter logic [31:0] IMPL_REV = 32'h0000_0A31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en_i,
    input  logic        wr_en_i,
    input  logic [4:0]  idx_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    input  logic        upd_valid_i,
    input  logic [5:0]  status_i,
    output logic [1:0]  rm_o,
    output logic        fs_o,
    output logic [7:0]  fcc_o,
    output logic        trap_o
);

    logic [CSR_W-1:0] csr_q;
    logic [CSR_W-1:0] after_wr;
    logic [CSR_W-1:0] after_upd;
    logic             trap_req;
    logic             trap_q;

    fpcsr_wr_merge u_wr (
        .cur_i   (csr_q),
        .wr_en_i (wr_en_i),
        .idx_i   (idx_i),
        .wdata_i (wdata_i),
        .nxt_o   (after_wr)
    );

    fpcsr_exc_merge u_exc (
        .base_i      (after_wr),
        .upd_valid_i (upd_valid_i),
        .status_i    (status_i),
        .nxt_o       (after_upd),
        .trap_req_o  (trap_req)
    );

    fpcsr_rd_view #(.IMPL_REV(IMPL_REV)) u_rd (
        .csr_i   (csr_q),
        .rd_en_i (rd_en_i),
        .idx_i   (idx_i),
        .rdata_o (rdata_o)
    );

    // Register the merged word and the trap request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            csr_q  <= after_upd;
            trap_q <= trap_req;
        end
    end

    // Drive the continuous control outputs from the stored word.
    always_comb begin
        rm_o   = csr_q[RM_LSB +: 2];
        fs_o   = csr_q[FS_POS];
        fcc_o  = fcc_gather(csr_q);
        trap_o = trap_q;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & RSV_MASK) == '0); // R6

    AST_TRAP_UNIMP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && status_i[UNIMP_B]) |=> trap_o); // R8

    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> !trap_o); // R8

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (idx_i == VIEW_EXC || idx_i == VIEW_ALL))
        |=> ((csr_q[FLG_LSB +: FLG_N] & $past(csr_q[FLG_LSB +: FLG_N]))
             == $past(csr_q[FLG_LSB +: FLG_N]))); // R9

    AST_FCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (idx_i == VIEW_CC || idx_i == VIEW_ALL)) |=> $stable(fcc_o)); // R3

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (idx_i == VIEW_ENA || idx_i == VIEW_ALL))
        |=> ($stable(rm_o) && $stable(fs_o))); // R5

endmodule

// File: tb/tb_fpcsr_unit.sv
module tb_fpcsr_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        upd = 1'b0;
    logic [5:0]  st = '0;
    logic [1:0]  rm;
    logic        fs;
    logic [7:0]  fcc;
    logic        trap;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] m = '0;
    logic        exp_trap = 1'b0;

    fpcsr_unit dut (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en), .idx_i(idx),
        .wdata_i(wdata), .rdata_o(rdata), .upd_valid_i(upd), .status_i(st),
        .rm_o(rm), .fs_o(fs), .fcc_o(fcc), .trap_o(trap)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cc_of(input logic [31:0] w);
        logic [8:0] v;
        v = 9'((w & 32'hFE80_0000) >> 23);
        return 8'((v & 9'd1) | (v >> 1));
    endfunction

    function automatic logic [31:0] model_wr(input logic [31:0] w, input logic [4:0] i,
                                             input logic [31:0] v);
        case (i)
            5'd25: return (w & ~32'hFE80_0000) | ((((v << 1) | (v & 32'd1)) << 23) & 32'hFE80_0000);
            5'd26: return (w & ~32'h0003_F07C) | (v & 32'h0003_F07C);
            5'd28: return (w & 32'hFE83_F07C) | (v & 32'h0000_0F83) | (v[2] ? 32'h0100_0000 : 32'd0);
            5'd31: return v & ~32'h007C_0000;
            default: return w;
        endcase
    endfunction

    // Read one view between clock edges.
    task automatic rd(input logic [4:0] i, output logic [31:0] d);
        idx = i; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    // One clock cycle with optional write and update, model advanced alongside.
    task automatic step(input bit w, input logic [4:0] i, input logic [31:0] v,
                        input bit u, input logic [5:0] s);
        logic [31:0] mw;
        wr_en = w; idx = i; wdata = v; upd = u; st = s;
        mw = w ? model_wr(m, i, v) : m;
        exp_trap = u && (((s[4:0] & mw[11:7]) != 0) || s[5]);
        if (u) mw = (mw & ~32'h0003_F000) | (32'(s) << 12) | (32'(s[4:0]) << 2);
        @(posedge clk);
        #1;
        m = mw;
        wr_en = 1'b0; upd = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(5'd31, d); chk("R1 full view", d, 32'd0);
        chk("R1 outputs", {22'd0, rm, fs, fcc, trap}, 32'd0);

        // R2 identification, ignored indices, idle read
        rd(5'd0, d); chk("R2 id", d, 32'h0000_0A31);
        step(1, 5'd0, 32'hFFFF_FFFF, 0, 0);
        step(1, 5'd5, 32'hFFFF_FFFF, 0, 0);
        rd(5'd31, d); chk("R2 ignored writes", d, 32'd0);
        step(1, 5'd31, 32'hFFFF_FFFF, 0, 0);
        rd(5'd5, d); chk("R2 unknown read", d, 32'd0);
        idx = 5'd31; #1 chk("R2 idle read", rdata, 32'd0);

        // R6 full view, reserved bits; R10 outputs
        rd(5'd31, d); chk("R6 full ones", d, 32'hFF83_FFFF);
        chk("R10 rm", 32'(rm), 32'd3);
        chk("R10 fs", 32'(fs), 32'd1);

        // R3 condition-code sweep with all other fields set
        for (int v = 0; v < 256; v++) begin
            step(1, 5'd25, 32'hFFFF_FF00 | 32'(v), 0, 0);
            rd(5'd25, d); chk("R3 cc read", d, 32'(v));
            chk("R10 fcc_o", 32'(fcc), 32'(cc_of(m)));
            rd(5'd31, d); chk("R3 full after cc", d, m);
        end

        // R5 enables view sweep
        for (int k = 0; k < 64; k++) begin
            logic [31:0] v;
            v = 32'(k) * 32'h9E37_79B1;
            step(1, 5'd28, v, 0, 0);
            rd(5'd28, d);
            chk("R5 ena read", d, (m & 32'h0000_0F83) | (m[24] ? 32'd4 : 32'd0));
            rd(5'd31, d); chk("R5 full after ena", d, m);
            chk("R10 rm fs", {29'd0, rm, fs}, {29'd0, m[1:0], m[24]});
        end

        // R4 exception view sweep
        for (int k = 0; k < 64; k++) begin
            logic [31:0] v;
            v = 32'(k) * 32'h85EB_CA6B;
            step(1, 5'd26, v, 0, 0);
            rd(5'd26, d); chk("R4 exc read", d, m & 32'h0003_F07C);
            rd(5'd31, d); chk("R4 full after exc", d, m);
        end

        // R7 R8 R9 status sweep across enable patterns
        for (int e = 0; e < 5; e++) begin
            logic [4:0] en;
            en = (e == 0) ? 5'h00 : (e == 1) ? 5'h1F : (e == 2) ? 5'h01 : (e == 3) ? 5'h10 : 5'h0A;
            step(1, 5'd28, 32'(en) << 7, 0, 0);
            for (int s = 0; s < 64; s++) begin
                logic [5:0] s2;
                s2 = 6'((s * 7 + 3) & 63);
                step(1, 5'd26, 32'd0, 0, 0);
                step(0, 5'd0, 32'd0, 1, 6'(s));
                chk("R8 trap", 32'(trap), 32'(exp_trap));
                rd(5'd26, d); chk("R7 cause", d, (32'(s) << 12) | (32'(s & 31) << 2));
                step(0, 5'd0, 32'd0, 1, s2);
                chk("R8 trap second", 32'(trap), 32'(exp_trap));
                rd(5'd26, d); chk("R9 sticky", d, (32'(s2) << 12) | (32'((s | s2) & 31) << 2));
                step(0, 5'd0, 32'd0, 0, 0);
                chk("R8 trap one cycle", 32'(trap), 32'd0);
            end
        end

        // R11 write and update in the same cycle
        step(1, 5'd31, 32'd0, 0, 0);
        step(1, 5'd28, 32'h0000_0F80, 1, 6'h01);
        chk("R11 trap new enables", 32'(trap), 32'd1);
        rd(5'd31, d); chk("R11 word", d, 32'h0000_1F84);
        step(1, 5'd26, 32'h0003_F07C, 1, 6'h00);
        rd(5'd26, d); chk("R11 write then clear cause", d, 32'h0000_007C);
        chk("R11 no trap", 32'(trap), 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule